// File: doc/BRIEF.md
# Serial-Access Word Memory Bridge

This block lets an external serial host read and write a small on-chip table of 32-bit words through a four-wire synchronous serial link (SPI, mode 0). Every exchange is a fixed frame of seven byte slots. The host first sends an opcode byte, then a filler byte that the block ignores, then the word index. A write then carries the new word in four bytes, most significant byte first. A read instead returns the stored word in those four slots, on the host's input line, most significant bit first. The host can read back any word it wrote and compare it with what it sent.

The three incoming serial pins are brought into the system clock through multi-stage synchronisers. All framing is done with sampled-edge detection in the system clock domain, so the block has a single clock. The logic on the fabric side sees the whole table through a registered read port: it presents an index and gets the word one clock later. Lifting chip select ends the frame at once. Only a frame that delivered all four write bytes changes the table.

Top module: `spi_wordmem_bridge`

## Requirements
- R1: After reset every word of the table reads as zero on the fabric port, and `spi_miso` is 0.
- R2: A frame whose first byte is 0x80, followed by any filler byte, an index byte and four data bytes (most significant byte first), stores that 32-bit word at the index. This holds at indices 0x00 and 0xFF as well.
- R3: In a read frame, bits 25 to 56 of the frame carry the stored word at the index given in byte 3, most significant bit first. The block changes `spi_miso` only after a falling SCK edge, and the host samples it on the rising edge.
- R4: `spi_miso` is 0 during the first 24 bits of a read frame, during the whole of a write frame, and whenever chip select is high.
- R5: A first byte other than 0x80 is handled as a read: it returns the stored word and leaves the table unchanged.
- R6: The value of the second byte has no effect on either writes or reads.
- R7: If chip select rises before the 56th bit of a write frame, the table does not change. The next frame is then decoded from its own first bit.
- R8: Bytes clocked after the seventh slot cause no further write. In a read frame, `spi_miso` stays 0 after the last bit of the word.
- R9: `fab_rdata` presents the word at `fab_addr` one clock after the index is applied, and it follows a new index on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; each SCK half-period must span at least four of its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| fab_addr | input | ADDR_W | Word index for the fabric read port |
| fab_rdata | output | DATA_W | Registered word read at `fab_addr` |

## Verification
Writes at the two end indices and at random indices are followed by reads. These tell whether the word bytes and the index bytes are assembled in the right order, and whether the MSB-first shift-out lines up with the slot after the index. Opcodes other than 0x80 and non-zero filler bytes show whether the decoder looks at the whole first byte and ignores the second. Chip select is dropped one bit short of the end and again early in the frame, and frames are lengthened with extra bytes. Together these separate a commit that waits for the last data bit from one that fires early, repeats or survives an abort. Randomised mixes of the three frame kinds then test the table against a model kept in the bench.

// File: rtl/spi_wordmem_pkg.sv
package spi_wordmem_pkg;

   localparam int BYTE_W     = 8;
   localparam int HDR_BYTES  = 3;
   localparam int IDX_OPCODE = 0;
   localparam int IDX_INDEX  = 2;
   localparam logic [BYTE_W-1:0] OPC_STORE = 8'h80;

   // pin bundle carried through the synchroniser
   typedef struct packed {
      logic cs_n;
      logic sck;
      logic mosi;
   } spi_pins_t;

   localparam spi_pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, mosi: 1'b0};

   function automatic int frame_bytes(input int data_w);
      return HDR_BYTES + data_w / BYTE_W;
   endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int              WIDTH     = 3,
   parameter int              STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RESET_VAL}};
      end else begin
         chain[0] <= din;
         for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
   import spi_wordmem_pkg::*;
#(
   parameter  int ADDR_W      = 8,
   parameter  int DATA_W      = 32,
   localparam int FRAME_BYTES = frame_bytes(DATA_W),
   localparam int POS_W       = $clog2(FRAME_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sck_s,
   input  logic              mosi_s,
   output logic [POS_W-1:0]  frame_pos,
   output logic [ADDR_W-1:0] peek_addr,
   input  logic [DATA_W-1:0] peek_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              miso
);

   localparam logic [POS_W-1:0] POS_END   = POS_W'(FRAME_BYTES);
   localparam logic [POS_W-1:0] POS_LAST  = POS_W'(FRAME_BYTES - 1);
   localparam logic [POS_W-1:0] POS_OPC   = POS_W'(IDX_OPCODE);
   localparam logic [POS_W-1:0] POS_INDEX = POS_W'(IDX_INDEX);
   localparam int               BIT_W     = $clog2(BYTE_W);

   logic                sck_q;
   logic [BIT_W-1:0]    bit_cnt;
   logic [BYTE_W-2:0]   rx_sr;
   logic [DATA_W-2:0]   wd_sr;
   logic                is_store;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   tx_sr;

   logic [BYTE_W-1:0]   cur_byte;
   logic                rise;
   logic                fall;
   logic                byte_done;
   logic                in_word;

   assign cur_byte  = {rx_sr, mosi_s};
   assign rise      = !cs_s &&  sck_s && !sck_q;
   assign fall      = !cs_s && !sck_s &&  sck_q;
   assign byte_done = rise && (bit_cnt == BIT_W'(BYTE_W - 1));
   assign in_word   = frame_pos > POS_INDEX;

   assign peek_addr = cur_byte[ADDR_W-1:0];
   assign wr_en     = byte_done && is_store && (frame_pos == POS_LAST);
   assign wr_addr   = addr_q;
   assign wr_data   = {wd_sr, mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q     <= 1'b0;
         bit_cnt   <= '0;
         rx_sr     <= '0;
         wd_sr     <= '0;
         is_store  <= 1'b0;
         addr_q    <= '0;
         tx_sr     <= '0;
         frame_pos <= '0;
         miso      <= 1'b0;
      end else begin
         sck_q <= sck_s;
         if (cs_s) begin
            bit_cnt   <= '0;
            frame_pos <= '0;
            is_store  <= 1'b0;
            tx_sr     <= '0;
            miso      <= 1'b0;
         end else begin
            if (rise) begin
               bit_cnt <= bit_cnt + 1'b1;
               rx_sr   <= cur_byte[BYTE_W-2:0];
               wd_sr   <= {wd_sr[DATA_W-3:0], mosi_s};
            end
            if (byte_done) begin
               if (frame_pos != POS_END) begin
                  frame_pos <= frame_pos + 1'b1;
               end
               if (frame_pos == POS_OPC) begin
                  is_store <= (cur_byte == OPC_STORE);
               end
               if (frame_pos == POS_INDEX) begin
                  addr_q <= cur_byte[ADDR_W-1:0];
                  tx_sr  <= is_store ? '0 : peek_data;
               end
            end
            if (fall && in_word && !is_store) begin
               miso  <= tx_sr[DATA_W-1];
               tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

endmodule

// File: rtl/spi_word_store.sv
module spi_word_store #(
   parameter  int ADDR_W         = 8,
   parameter  int DATA_W         = 32,
   parameter  bit CLEAR_ON_RESET = 1'b1,
   localparam int DEPTH          = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] peek_addr,
   output logic [DATA_W-1:0] peek_data,
   input  logic [ADDR_W-1:0] fab_addr,
   output logic [DATA_W-1:0] fab_rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) begin
                  mem[i] <= '0;
               end
            end else if (wr_en) begin
               mem[wr_addr] <= wr_data;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (wr_en) begin
               mem[wr_addr] <= wr_data;
            end
         end
      end
   endgenerate

   assign peek_data = mem[peek_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fab_rdata <= '0;
      end else begin
         fab_rdata <= mem[fab_addr];
      end
   end

endmodule

// File: rtl/spi_wordmem_bridge.sv
module spi_wordmem_bridge
   import spi_wordmem_pkg::*;
#(
   parameter int ADDR_W         = 8,
   parameter int DATA_W         = 32,
   parameter int SYNC_STAGES    = 2,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   input  logic [ADDR_W-1:0] fab_addr,
   output logic [DATA_W-1:0] fab_rdata
);

   localparam int FRAME_BYTES = frame_bytes(DATA_W);
   localparam int POS_W       = $clog2(FRAME_BYTES + 1);

   generate
      if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_addr
         $error("ADDR_W must fit in the single index byte");
      end
      if (DATA_W < 16 || (DATA_W % BYTE_W) != 0) begin : g_bad_data
         $error("DATA_W must be a whole number of bytes, at least two");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   spi_pins_t           pins_raw;
   spi_pins_t           pins_s;
   logic                cs_s;
   logic                sck_s;
   logic [POS_W-1:0]    frame_pos;
   logic [ADDR_W-1:0]   peek_addr;
   logic [DATA_W-1:0]   peek_data;
   logic                wr_en;
   logic [ADDR_W-1:0]   wr_addr;
   logic [DATA_W-1:0]   wr_data;
   logic                miso;

   assign pins_raw = '{cs_n: spi_cs_n, sck: spi_sck, mosi: spi_mosi};

   spi_pin_sync #(
      .WIDTH     ($bits(spi_pins_t)),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (PINS_IDLE)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pins_raw),
      .dout (pins_s)
   );

   assign cs_s  = pins_s.cs_n;
   assign sck_s = pins_s.sck;

   spi_frame_engine #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_s     (cs_s),
      .sck_s    (sck_s),
      .mosi_s   (pins_s.mosi),
      .frame_pos(frame_pos),
      .peek_addr(peek_addr),
      .peek_data(peek_data),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .miso     (miso)
   );

   spi_word_store #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .peek_addr(peek_addr),
      .peek_data(peek_data),
      .fab_addr (fab_addr),
      .fab_rdata(fab_rdata)
   );

   assign spi_miso = miso;

endmodule

// File: rtl/spi_wordmem_checker.sv
module spi_wordmem_checker #(
   parameter int FRAME_BYTES = 7,
   parameter int POS_W       = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_s,
   input logic             sck_s,
   input logic             miso,
   input logic             wr_en,
   input logic [POS_W-1:0] frame_pos
);

   // R4: deselected link returns MISO to zero on the next clock
   a_r4_idle_miso: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !miso);

   // R3: while selected, MISO only moves right after a falling SCK edge
   a_r3_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!cs_s) && (miso != $past(miso))) |-> ($past(sck_s, 2) && !$past(sck_s)));

   // R2: one commit strobe per frame
   a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R2: a commit closes the frame
   a_r2_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (frame_pos == POS_W'(FRAME_BYTES)));

   // R7: deselect rewinds the byte position
   a_r7_abort_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> (frame_pos == '0));

   // R8: the byte position never runs past the end slot
   a_r8_pos_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      frame_pos <= POS_W'(FRAME_BYTES));

   // R7: no commit while deselected
   a_r7_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !cs_s);

endmodule

bind spi_wordmem_bridge spi_wordmem_checker #(
   .FRAME_BYTES(FRAME_BYTES),
   .POS_W      (POS_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_s     (cs_s),
   .sck_s    (sck_s),
   .miso     (miso),
   .wr_en    (wr_en),
   .frame_pos(frame_pos)
);

// File: tb/sim_spi_wordmem_bridge.sv
`timescale 1ns/1ps
module sim_spi_wordmem_bridge;

   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0;
   logic        cs_n = 1'b1;
   logic        mosi = 1'b0;
   logic        miso;
   logic [7:0]  fab_addr = '0;
   logic [31:0] fab_rdata;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [31:0] model [256];

   always #2.5 clk = ~clk;

   spi_wordmem_bridge u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_sck  (sck),
      .spi_cs_n (cs_n),
      .spi_mosi (mosi),
      .spi_miso (miso),
      .fab_addr (fab_addr),
      .fab_rdata(fab_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic spi_run(input logic [71:0] tx, input int nbits, output logic [71:0] rx);
      rx = '0;
      @(negedge clk);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int k = 0; k < nbits; k++) begin
         mosi = tx[71-k];
         repeat (HALF) @(negedge clk);
         rx  = {rx[70:0], miso};
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      mosi = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   function automatic logic [31:0] expect_word(input logic [7:0] cmd, input logic [7:0] a);
      return (cmd == 8'h80) ? 32'h0 : model[a];
   endfunction

   // full 7-slot frame; checks header silence, returned word and idle MISO
   task automatic frame7(input string req, input logic [7:0] cmd, input logic [7:0] pad,
                         input logic [7:0] a, input logic [31:0] data);
      logic [71:0] rx;
      logic [31:0] exp;
      exp = expect_word(cmd, a);
      spi_run({cmd, pad, a, data, 16'h0}, 56, rx);
      chk({req, " R4 header"}, {8'h0, rx[55:32]}, 32'h0);
      chk({req, " R3 word"}, rx[31:0], exp);
      chk("R4 idle miso", {31'h0, miso}, 32'h0);
      if (cmd == 8'h80) model[a] = data;
   endtask

   task automatic fab_check(input string req, input logic [7:0] a);
      @(negedge clk);
      fab_addr = a;
      @(negedge clk);
      chk(req, fab_rdata, model[a]);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) model[i] = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1: reset state
      chk("R1 miso", {31'h0, miso}, 32'h0);
      fab_check("R1 idx00", 8'h00);
      fab_check("R1 idxFF", 8'hFF);
      fab_check("R1 idx5A", 8'h5A);

      // R2: writes at the end indices and inside
      frame7("R2 wr00", 8'h80, 8'h00, 8'h00, 32'hDEADBEEF);
      fab_check("R2 fab00", 8'h00);
      frame7("R2 wrFF", 8'h80, 8'h00, 8'hFF, 32'h01234567);
      fab_check("R2 fabFF", 8'hFF);
      frame7("R2 wr33", 8'h80, 8'h00, 8'h33, 32'h80000001);
      fab_check("R2 fab33", 8'h33);

      // R3: reads of the written words
      frame7("R3 rd00", 8'h00, 8'h00, 8'h00, 32'h0);
      frame7("R3 rdFF", 8'h00, 8'h00, 8'hFF, 32'h0);
      frame7("R3 rd33", 8'h00, 8'h00, 8'h33, 32'h0);

      // R5: other opcodes behave as reads and never write
      frame7("R5 op01", 8'h01, 8'h00, 8'h00, 32'h11111111);
      fab_check("R5 fab00", 8'h00);
      frame7("R5 opFF", 8'hFF, 8'h00, 8'hFF, 32'h22222222);
      fab_check("R5 fabFF", 8'hFF);
      frame7("R5 op81", 8'h81, 8'h00, 8'h33, 32'h33333333);
      fab_check("R5 fab33", 8'h33);

      // R6: filler byte ignored
      frame7("R6 wr", 8'h80, 8'hA5, 8'h40, 32'hCAFEF00D);
      fab_check("R6 fab40", 8'h40);
      frame7("R6 rd", 8'h00, 8'hFF, 8'h40, 32'h0);

      // R7: abort one bit short, then early, then a clean frame
      begin
         logic [71:0] rx;
         spi_run({8'h80, 8'h00, 8'h40, 32'h12345678, 16'h0}, 55, rx);
         fab_check("R7 short55", 8'h40);
         spi_run({8'h80, 8'h00, 8'h40, 32'h9ABCDEF0, 16'h0}, 20, rx);
         fab_check("R7 short20", 8'h40);
      end
      frame7("R7 resync", 8'h80, 8'h00, 8'h41, 32'h0BADC0DE);
      fab_check("R7 fab41", 8'h41);

      // R8: overlong frames
      begin
         logic [71:0] rx;
         spi_run({8'h80, 8'h00, 8'h42, 32'h55AA55AA, 16'hFFFF}, 72, rx);
         model[8'h42] = 32'h55AA55AA;
         fab_check("R8 extra wr", 8'h42);
         spi_run({8'h00, 8'h00, 8'h42, 32'h0, 16'hFFFF}, 72, rx);
         chk("R8 word", rx[47:16], 32'h55AA55AA);
         chk("R8 trail", {16'h0, rx[15:0]}, 32'h0);
      end

      // R9: new index each clock
      @(negedge clk);
      fab_addr = 8'h00;
      @(negedge clk);
      chk("R9 seq0", fab_rdata, model[8'h00]);
      fab_addr = 8'hFF;
      @(negedge clk);
      chk("R9 seq1", fab_rdata, model[8'hFF]);
      fab_addr = 8'h33;
      @(negedge clk);
      chk("R9 seq2", fab_rdata, model[8'h33]);

      // random mix
      void'($urandom(32'd4242));
      for (int n = 0; n < 50; n++) begin
         logic [7:0] a;
         logic [7:0] c;
         int kind;
         kind = int'($urandom % 4);
         a = ($urandom % 2) ? (8'hF8 | 8'($urandom % 8)) : 8'($urandom % 8);
         case (kind)
            0, 1: begin
               frame7("R2 rnd wr", 8'h80, 8'($urandom), a, $urandom);
               fab_check("R2 rnd fab", a);
            end
            2: frame7("R3 rnd rd", 8'h00, 8'($urandom), a, $urandom);
            default: begin
               c = 8'($urandom);
               if (c == 8'h80) c = 8'h7F;
               frame7("R5 rnd op", c, 8'h00, a, $urandom);
               fab_check("R5 rnd fab", a);
            end
         endcase
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule